// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a display transmitter. On every pixel clock it steps a horizontal pixel counter and a vertical line counter. From those counters it decodes horizontal sync, vertical sync, a data-enable strobe and a line-active flag, and it also brings out the raw pixel and line positions. A host sets the active size, both porches and the sync widths of each axis through a simple write port. The host also sets the sync polarities and an optional pixel-repeat mode that doubles every horizontal quantity.

Each timing word packs the vertical quantity in its upper half and the horizontal quantity in its lower half. Every field holds the wanted count minus one. The "span" field runs from the start of sync to the end of the line or frame, so it includes the sync pulse. Writes to timing, polarity and the repeat bit go to a programmed copy. The working copy takes them only at a frame boundary, so a frame is never torn. The enable bit acts at once. Two further control bits, for transmitter mode and interlace, are stored and shown on outputs only.

Top module: `vtg_top`

## Requirements
- R1: While the enable bit (control word, address 0, bit 31) is clear, including after reset, de and line_active are 0, hsync and vsync sit at their inactive level, and pix_x and line_y are 0.
- R2: The timing words sit at addresses 1 (active), 2 (span from sync start to end of line/frame), 3 (front porch) and 4 (sync width). Each holds the vertical value in bits 31:16 and the horizontal value in bits 15:0, low FIELD_W bits used, stored as count minus one.
- R3: A line lasts active + front + span pixels. pix_x counts 0 up to that total minus 1, one step per clock. de is 1 exactly when pix_x < active on a line with line_y < vertical active.
- R4: hsync is at its active level exactly when active + front <= pix_x < active + front + sync width.
- R5: line_y advances once per completed line and wraps after active + front + span lines. line_active is 1 for line_y < vertical active. vsync is active exactly when vertical active + front <= line_y < that sum + sync width.
- R6: Polarity word (address 5): bit 1 set makes vsync active high and bit 0 set makes hsync active high. A clear bit makes that sync active low.
- R7: Control bit 0 set doubles the horizontal active, span, front porch and sync width counts. Vertical counts are unchanged.
- R8: New timing, polarity or repeat values written while running take effect at the next frame start (pix_x = 0, line_y = 0). The frame in progress completes with the old values.
- R9: Control bits 30 and 4 appear on hdmi_mode and interlace from the cycle after the write and do not change the timing.
- R10: In the cycle after the enable bit is written to 1, the outputs show pixel 0 of line 0. In the cycle after it is written to 0, the outputs and counters are at their R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity programmable |
| vsync | output | 1 | Vertical sync, polarity programmable |
| de | output | 1 | Data enable, active pixel on active line |
| line_active | output | 1 | Current line is in the vertical active region |
| pix_x | output | FIELD_W+3 | Horizontal pixel position |
| line_y | output | FIELD_W+3 | Vertical line position |
| hdmi_mode | output | 1 | Stored transmitter-mode control bit |
| interlace | output | 1 | Stored interlace control bit |

## Verification
A wrong counter value or a wrong working-copy field shows up within one line as a misplaced de edge or sync edge. It also shows up directly on pix_x and line_y in the same cycle it arises. A shadow copy loaded at the wrong moment leaves the frame in progress with the wrong length or sync placement, visible before the next frame start. The bench steps through whole frames in several configurations and compares every output on every cycle against positions computed by division and remainder of a cycle index. The configurations cover both polarities, repeat on and off, and a timing change in the middle of a frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int VTG_AW = 3;

  localparam logic [VTG_AW-1:0] ADR_CTRL  = 3'd0;
  localparam logic [VTG_AW-1:0] ADR_ACT   = 3'd1;
  localparam logic [VTG_AW-1:0] ADR_POL   = 3'd5;

  localparam int N_FIELDS = 4;
  localparam int FLD_ACT   = 0;
  localparam int FLD_SPAN  = 1;
  localparam int FLD_FRONT = 2;
  localparam int FLD_SYNC  = 3;

  localparam int BIT_EN    = 31;
  localparam int BIT_HDMI  = 30;
  localparam int BIT_ILACE = 4;
  localparam int BIT_REP   = 0;
  localparam int BIT_VPOL  = 1;
  localparam int BIT_HPOL  = 0;
  localparam int VERT_LSB  = 16;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int FW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [VTG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              load,
  output logic              en_q,
  output logic              en_d,
  output logic              hdmi_mode,
  output logic              interlace,
  output logic              w_rep,
  output logic              w_hpol,
  output logic              w_vpol,
  output logic [N_FIELDS-1:0][FW-1:0] w_h,
  output logic [N_FIELDS-1:0][FW-1:0] w_v
);
  logic [FW-1:0] p_h [N_FIELDS];
  logic [FW-1:0] p_v [N_FIELDS];
  logic [FW-1:0] k_h [N_FIELDS];
  logic [FW-1:0] k_v [N_FIELDS];

  logic p_rep, p_hpol, p_vpol, hdmi_q, ilace_q;
  logic p_rep_n, p_hpol_n, p_vpol_n, hdmi_n, ilace_n, en_n;
  logic k_rep, k_hpol, k_vpol;

  logic ctrl_wr, pol_wr;
  assign ctrl_wr = we && (addr == ADR_CTRL);
  assign pol_wr  = we && (addr == ADR_POL);
  assign en_d    = en_n;

  always_comb begin
    en_n     = en_q;
    p_rep_n  = p_rep;
    hdmi_n   = hdmi_q;
    ilace_n  = ilace_q;
    p_hpol_n = p_hpol;
    p_vpol_n = p_vpol;
    if (ctrl_wr) begin
      en_n    = wdata[BIT_EN];
      p_rep_n = wdata[BIT_REP];
      hdmi_n  = wdata[BIT_HDMI];
      ilace_n = wdata[BIT_ILACE];
    end
    if (pol_wr) begin
      p_hpol_n = wdata[BIT_HPOL];
      p_vpol_n = wdata[BIT_VPOL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      p_rep   <= 1'b0;
      hdmi_q  <= 1'b0;
      ilace_q <= 1'b0;
      p_hpol  <= 1'b0;
      p_vpol  <= 1'b0;
    end else begin
      en_q    <= en_n;
      p_rep   <= p_rep_n;
      hdmi_q  <= hdmi_n;
      ilace_q <= ilace_n;
      p_hpol  <= p_hpol_n;
      p_vpol  <= p_vpol_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_rep  <= 1'b0;
      k_hpol <= 1'b0;
      k_vpol <= 1'b0;
    end else if (load) begin
      k_rep  <= p_rep;
      k_hpol <= p_hpol;
      k_vpol <= p_vpol;
    end
  end

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
    localparam logic [VTG_AW-1:0] MY_ADR = VTG_AW'(int'(ADR_ACT) + i);
    logic [FW-1:0] ph_n, pv_n;
    logic          hit;

    assign hit = we && (addr == MY_ADR);

    always_comb begin
      ph_n = p_h[i];
      pv_n = p_v[i];
      if (hit) begin
        ph_n = wdata[FW-1:0];
        pv_n = wdata[VERT_LSB +: FW];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        p_h[i] <= '0;
        p_v[i] <= '0;
      end else begin
        p_h[i] <= ph_n;
        p_v[i] <= pv_n;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        k_h[i] <= '0;
        k_v[i] <= '0;
      end else if (load) begin
        k_h[i] <= p_h[i];
        k_v[i] <= p_v[i];
      end
    end

    assign w_h[i] = k_h[i];
    assign w_v[i] = k_v[i];
  end

  assign hdmi_mode = hdmi_q;
  assign interlace = ilace_q;
  assign w_rep     = k_rep;
  assign w_hpol    = k_hpol;
  assign w_vpol    = k_vpol;
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [CW-1:0] act,
  input  logic [CW-1:0] front,
  input  logic [CW-1:0] span,
  input  logic [CW-1:0] swidth,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] total,
  output logic          wrap,
  output logic          in_act,
  output logic          in_sync
);
  logic [CW-1:0] cnt_n, sync_lo, sync_hi;
  logic          last;

  assign total   = act + front + span;
  assign last    = (cnt == total - CW'(1));
  assign wrap    = adv && last;
  assign sync_lo = act + front;
  assign sync_hi = sync_lo + swidth;
  assign in_act  = (cnt < act);
  assign in_sync = (cnt >= sync_lo) && (cnt < sync_hi);

  always_comb begin
    cnt_n = cnt;
    if (clr)       cnt_n = '0;
    else if (wrap) cnt_n = '0;
    else if (adv)  cnt_n = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int FIELD_W = 12,
  localparam int CW = FIELD_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [VTG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              line_active,
  output logic [CW-1:0]     pix_x,
  output logic [CW-1:0]     line_y,
  output logic              hdmi_mode,
  output logic              interlace
);
  logic en_q, en_d, w_rep, w_hpol, w_vpol;
  logic [N_FIELDS-1:0][FIELD_W-1:0] w_h, w_v;
  logic [CW-1:0] hc [N_FIELDS];
  logic [CW-1:0] vc [N_FIELDS];
  logic [CW-1:0] h_total, v_total;
  logic h_wrap, v_wrap, h_act, v_act, h_sync, v_sync;
  logic load, clr;

  assign clr  = !en_q || !en_d;
  assign load = !en_q || v_wrap;

  vtg_regs #(.FW(FIELD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(load), .en_q(en_q), .en_d(en_d), .hdmi_mode(hdmi_mode),
    .interlace(interlace), .w_rep(w_rep), .w_hpol(w_hpol), .w_vpol(w_vpol),
    .w_h(w_h), .w_v(w_v)
  );

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_cnt
    logic [CW-1:0] h_base;
    assign h_base = CW'(w_h[i]) + CW'(1);
    assign hc[i]  = w_rep ? (h_base << 1) : h_base;
    assign vc[i]  = CW'(w_v[i]) + CW'(1);
  end

  vtg_axis #(.CW(CW)) u_h (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(1'b1),
    .act(hc[FLD_ACT]), .front(hc[FLD_FRONT]), .span(hc[FLD_SPAN]),
    .swidth(hc[FLD_SYNC]), .cnt(pix_x), .total(h_total), .wrap(h_wrap),
    .in_act(h_act), .in_sync(h_sync)
  );

  vtg_axis #(.CW(CW)) u_v (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(h_wrap),
    .act(vc[FLD_ACT]), .front(vc[FLD_FRONT]), .span(vc[FLD_SPAN]),
    .swidth(vc[FLD_SYNC]), .cnt(line_y), .total(v_total), .wrap(v_wrap),
    .in_act(v_act), .in_sync(v_sync)
  );

  always_comb begin
    de          = en_q && h_act && v_act;
    line_active = en_q && v_act;
    hsync       = (en_q && h_sync) ? w_hpol : !w_hpol;
    vsync       = (en_q && v_sync) ? w_vpol : !w_vpol;
  end
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int CW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_q,
  input logic          de,
  input logic          hsync,
  input logic          vsync,
  input logic          w_hpol,
  input logic          w_vpol,
  input logic [CW-1:0] pix_x,
  input logic [CW-1:0] line_y,
  input logic [CW-1:0] h_total
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!de && hsync == !w_hpol && vsync == !w_vpol && pix_x == '0 && line_y == '0));

  assert_pixel_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != '0) |-> (pix_x == $past(pix_x) + CW'(1)));

  assert_pixel_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (pix_x < h_total));

  assert_hsync_off_in_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync == !w_hpol));

  assert_line_moves_at_x0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_y) |-> (pix_x == '0));

  assert_vsync_off_in_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (vsync == !w_vpol));
endmodule

bind vtg_top vtg_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .de(de), .hsync(hsync), .vsync(vsync),
  .w_hpol(w_hpol), .w_vpol(w_vpol), .pix_x(pix_x), .line_y(line_y),
  .h_total(h_total)
);

// File: tb/tb_vtg_top.sv
module tb_vtg_top;
  localparam int FW = 12;
  localparam int CW = FW + 3;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_addr;
  logic [31:0]   cfg_wdata;
  logic          hsync, vsync, de, line_active, hdmi_mode, interlace;
  logic [CW-1:0] pix_x, line_y;

  vtg_top #(.FIELD_W(FW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync), .de(de),
    .line_active(line_active), .pix_x(pix_x), .line_y(line_y),
    .hdmi_mode(hdmi_mode), .interlace(interlace)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  string req  = "R1";

  // reference model state
  int prog_h[4], prog_v[4], cur_h[4], cur_v[4];
  bit prog_rep, cur_rep, en, prog_hdmi, prog_il;
  bit [1:0] prog_pol, cur_pol;
  int cidx;

  function automatic int h_len(int i);
    return (cur_h[i] + 1) << cur_rep;
  endfunction
  function automatic int v_len(int i);
    return cur_v[i] + 1;
  endfunction
  function automatic int frame_len();
    return (h_len(0) + h_len(1) + h_len(2)) * (v_len(0) + v_len(1) + v_len(2));
  endfunction

  task automatic check();
    int ha, hf, hs, ht, va, vf, vs, ex, ey;
    bit ede, ela, ehs, evs;
    ha = h_len(0); hf = h_len(2); hs = h_len(3); ht = ha + hf + h_len(1);
    va = v_len(0); vf = v_len(2); vs = v_len(3);
    ex = en ? cidx % ht : 0;
    ey = en ? cidx / ht : 0;
    ede = en && ex < ha && ey < va;
    ela = en && ey < va;
    ehs = (en && ex >= ha + hf && ex < ha + hf + hs) ? cur_pol[0] : !cur_pol[0];
    evs = (en && ey >= va + vf && ey < va + vf + vs) ? cur_pol[1] : !cur_pol[1];
    n_tests++;
    if (int'(pix_x) != ex || int'(line_y) != ey || de !== ede || line_active !== ela ||
        hsync !== ehs || vsync !== evs || hdmi_mode !== prog_hdmi || interlace !== prog_il) begin
      n_fail++;
      $display("FAIL %s: x=%0d/%0d y=%0d/%0d de=%b/%b la=%b/%b hs=%b/%b vs=%b/%b hm=%b/%b il=%b/%b",
               req, pix_x, ex, line_y, ey, de, ede, line_active, ela, hsync, ehs,
               vsync, evs, hdmi_mode, prog_hdmi, interlace, prog_il);
    end
  endtask

  task automatic model_edge(bit w, logic [2:0] a, logic [31:0] d);
    bit en_new;
    en_new = (w && a == 3'd0) ? d[31] : en;
    if (!en) begin
      cur_h = prog_h; cur_v = prog_v; cur_rep = prog_rep; cur_pol = prog_pol;
      cidx = 0;
    end else begin
      if (cidx == frame_len() - 1) begin
        cur_h = prog_h; cur_v = prog_v; cur_rep = prog_rep; cur_pol = prog_pol;
        cidx = 0;
      end else begin
        cidx++;
      end
      if (!en_new) cidx = 0;
    end
    if (w) begin
      case (a)
        3'd0: begin prog_rep = d[0]; prog_hdmi = d[30]; prog_il = d[4]; end
        3'd1, 3'd2, 3'd3, 3'd4: begin
          prog_h[int'(a) - 1] = int'(d[FW-1:0]);
          prog_v[int'(a) - 1] = int'(d[16 +: FW]);
        end
        3'd5: prog_pol = d[1:0];
        default: ;
      endcase
    end
    en = en_new;
  endtask

  task automatic step(bit w, logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    check();
    cfg_we = w; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    model_edge(w, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    step(1'b1, a, d);
  endtask

  function automatic logic [31:0] word(int v, int h);
    return {16'(v), 16'(h)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin prog_h[i] = 0; prog_v[i] = 0; cur_h[i] = 0; cur_v[i] = 0; end
    prog_rep = 0; cur_rep = 0; en = 0; prog_hdmi = 0; prog_il = 0;
    prog_pol = 2'b00; cur_pol = 2'b00; cidx = 0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    req = "R1";            // reset state: idle, syncs high (active low)
    idle(3);

    req = "R2";            // program fields as count minus one
    wr(3'd1, word(2, 3));  // active: 3 lines, 4 pixels
    wr(3'd2, word(2, 4));  // span: 3 lines, 5 pixels
    wr(3'd3, word(0, 1));  // front: 1 line, 2 pixels
    wr(3'd4, word(1, 1));  // sync: 2 lines, 2 pixels
    req = "R1";
    idle(2);               // still disabled
    req = "R10";
    wr(3'd0, 32'h8000_0000);
    req = "R3";            // R4 and R5 checked on every cycle too
    idle(77 * 2 + 5);

    req = "R10";           // disable mid-frame
    wr(3'd0, 32'h0000_0000);
    req = "R1";
    idle(8);

    req = "R6";            // active-high syncs
    wr(3'd5, 32'h0000_0003);
    req = "R7";            // repeat doubles horizontal counts
    wr(3'd0, 32'h8000_0001);
    idle(22 * 7 * 2 + 3);

    req = "R8";            // change everything mid-frame
    idle(30);
    wr(3'd1, word(3, 5));
    wr(3'd2, word(3, 6));
    wr(3'd3, word(1, 2));
    wr(3'd4, word(0, 2));
    wr(3'd5, 32'h0000_0001);
    wr(3'd0, 32'h8000_0000);
    idle(154 + 160 * 2);

    req = "R9";            // reported control bits leave timing alone
    wr(3'd0, 32'hC000_0010);
    idle(170);
    wr(3'd0, 32'h8000_0000);
    idle(20);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule